// File: doc/BRIEF.md
# Low Pin Count Bus Target Cycle Engine

This block is the target side of a Low Pin Count host bus for a peripheral. It runs on the bus clock, watches the framing strobe and the 4-bit multiplexed address/data lines, and decodes each cycle the host starts. It claims single-byte I/O reads and writes, single-byte DMA transfers in both directions, and single-byte memory reads and writes whose address lands inside a fixed firmware window. For every claimed cycle it presents one access on a simple register-side port: address, space, write data and a one-clock read or write strobe. Read data comes back on the same port.

The engine only drives the shared lines during its own sync, read-data and closing turn-around phases. Everything it does not claim is left alone: the bus stays released and no strobe is raised. A frame strobe seen in the middle of a cycle abandons that cycle at once.

Top module: `lpc_target_engine`

## Requirements
- R1: While `rst_n` is low, and in the first clock after it rises, `lad_oe`, `reg_wr` and `reg_rd` are 0.
- R2: A clock with `lframe_n` low and `lad_in` = 0000 starts a cycle, and the next nibble is its type. `lframe_n` low in any state ends the current cycle: with 0000 a new cycle starts, with any other nibble the engine waits idle. `lad_oe` is 0 in the clock after any clock with `lframe_n` low.
- R3: Type 001x is an I/O write. Four address nibbles follow, most significant first, then the data byte as low nibble and then high nibble. The result is one `reg_wr` pulse with `reg_space` = 00, `reg_addr` equal to the 16-bit address zero-extended, and `reg_wdata` equal to the byte.
- R4: Type 000x is an I/O read with the same address format. The result is one `reg_rd` pulse with `reg_space` = 00. `reg_rdata` is sampled in that clock and returned low nibble first, then high nibble.
- R5: Two host turn-around clocks follow the last host nibble. The engine then drives 0101 for `WAIT_CYC` clocks, then 0000 for one clock, then any read data, then 1111 for one clock, and then releases the bus. The strobe is raised in the first sync clock.
- R6: Type 010x is a memory read and 011x a memory write, each with eight address nibbles, most significant first. They are claimed (`reg_space` = 01) only if `WIN_BASE` <= address <= `WIN_BASE+WIN_SIZE-1`. Outside that range the cycle is ignored.
- R7: Type 100x is a DMA transfer in which the host supplies the byte (`reg_wr`). Type 101x is a DMA transfer in which the target returns it (`reg_rd`). Each carries a channel nibble and then a size nibble. Only a size nibble with bits [1:0] = 00 is claimed, with `reg_space` = 10 and `reg_addr` equal to the channel. Other sizes are ignored.
- R8: Types 11xx are ignored: no drive, no strobe, and the engine waits for the next start.
- R9: `reg_wr` and `reg_rd` are never high together, and each lasts exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low bus reset, asynchronous |
| lframe_n | input | 1 | Active-low cycle framing strobe |
| lad_in | input | 4 | Nibble received from the shared lines |
| lad_out | output | 4 | Nibble the target drives |
| lad_oe | output | 1 | Output enable for `lad_out` |
| reg_addr | output | 32 | Access address (channel for DMA) |
| reg_space | output | 2 | 00 I/O, 01 memory, 10 DMA |
| reg_wdata | output | 8 | Write data byte |
| reg_wr | output | 1 | One-clock write strobe |
| reg_rd | output | 1 | One-clock read strobe |
| reg_rdata | input | 8 | Read data, sampled in the `reg_rd` clock |

## Verification
Cycle abandonment and cycle start can land in the same clock. This happens when the framing strobe returns with a start nibble while the address of an I/O write is still arriving. The bench provokes it by cutting a write after two address nibbles and following at once with a complete I/O read. The scoreboard must then see only the read strobe, with the read's address, and the read nibbles must come back at their normal positions. A second cut with a non-start nibble must leave the bus silent until the next proper cycle.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;
    localparam int NIB_W    = 4;
    localparam int ADDR_W   = 32;
    localparam int DATA_W   = 8;
    localparam int IO_NIBS  = 4;
    localparam int MEM_NIBS = 8;

    localparam logic [NIB_W-1:0] NIB_START = 4'b0000;
    localparam logic [NIB_W-1:0] NIB_WAIT  = 4'b0101;
    localparam logic [NIB_W-1:0] NIB_READY = 4'b0000;
    localparam logic [NIB_W-1:0] NIB_IDLE  = 4'b1111;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTYPE,
        ST_ADDR,
        ST_CHAN,
        ST_SIZE,
        ST_WDATA,
        ST_TAR_IN,
        ST_SYNC,
        ST_RDATA,
        ST_TAR_OUT
    } lpc_state_e;

    typedef enum logic [1:0] {
        SP_IO  = 2'b00,
        SP_MEM = 2'b01,
        SP_DMA = 2'b10
    } lpc_space_e;
endpackage

// File: rtl/lpc_cmd_decode.sv
module lpc_cmd_decode
    import lpc_tgt_pkg::*;
(
    input  logic [NIB_W-1:0] ctype,
    output logic             ok,
    output lpc_space_e       space,
    output logic             host_data
);
    // bit 0 of the type nibble is don't-care
    always_comb begin
        ok        = 1'b1;
        space     = SP_IO;
        host_data = 1'b0;
        unique case (ctype[3:1])
            3'b000: begin space = SP_IO;  host_data = 1'b0; end
            3'b001: begin space = SP_IO;  host_data = 1'b1; end
            3'b010: begin space = SP_MEM; host_data = 1'b0; end
            3'b011: begin space = SP_MEM; host_data = 1'b1; end
            3'b100: begin space = SP_DMA; host_data = 1'b1; end
            3'b101: begin space = SP_DMA; host_data = 1'b0; end
            default: ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/lpc_win_check.sv
module lpc_win_check
    import lpc_tgt_pkg::*;
#(
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'hFFF0_0000,
    parameter logic [ADDR_W-1:0] WIN_SIZE = 32'h0010_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    generate
        if (WIN_SIZE == '0) begin : g_empty
            assign hit = 1'b0;
        end else begin : g_range
            logic [ADDR_W-1:0] offset;
            assign offset = addr - WIN_BASE;
            assign hit    = (addr >= WIN_BASE) && (offset < WIN_SIZE);
        end
    endgenerate
endmodule

// File: rtl/lpc_lad_driver.sv
module lpc_lad_driver
    import lpc_tgt_pkg::*;
(
    input  lpc_state_e        st,
    input  logic              half,
    input  logic              ready,
    input  logic [DATA_W-1:0] data,
    output logic [NIB_W-1:0]  lad_out,
    output logic              lad_oe
);
    always_comb begin
        lad_out = NIB_IDLE;
        lad_oe  = 1'b0;
        unique case (st)
            ST_SYNC: begin
                lad_oe  = 1'b1;
                lad_out = ready ? NIB_READY : NIB_WAIT;
            end
            ST_RDATA: begin
                lad_oe  = 1'b1;
                lad_out = half ? data[7:4] : data[3:0];
            end
            ST_TAR_OUT: begin
                lad_oe  = !half;
                lad_out = NIB_IDLE;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lpc_target_engine.sv
module lpc_target_engine
    import lpc_tgt_pkg::*;
#(
    parameter int                WAIT_CYC = 2,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'hFFF0_0000,
    parameter logic [ADDR_W-1:0] WIN_SIZE = 32'h0010_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lframe_n,
    input  logic [NIB_W-1:0]  lad_in,
    output logic [NIB_W-1:0]  lad_out,
    output logic              lad_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [1:0]        reg_space,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    input  logic [DATA_W-1:0] reg_rdata
);
    localparam int WCW = (WAIT_CYC < 1) ? 1 : $clog2(WAIT_CYC + 1);
    localparam logic [2:0] IO_LAST  = 3'(IO_NIBS - 1);
    localparam logic [2:0] MEM_LAST = 3'(MEM_NIBS - 1);

    typedef struct packed {
        lpc_state_e        st;
        lpc_space_e        space;
        logic              host_data;
        logic [2:0]        cnt;
        logic [WCW-1:0]    wcnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              wr_stb;
        logic              rd_stb;
    } eng_t;

    eng_t q, d;

    logic              dec_ok;
    lpc_space_e        dec_space;
    logic              dec_host;
    logic [ADDR_W-1:0] addr_shift;
    logic              win_hit;
    logic              sync_ready;
    logic [2:0]        last_nib;

    assign addr_shift = {q.addr[ADDR_W-NIB_W-1:0], lad_in};
    assign sync_ready = (q.wcnt == WCW'(WAIT_CYC));
    assign last_nib   = (q.space == SP_MEM) ? MEM_LAST : IO_LAST;

    lpc_cmd_decode u_dec (
        .ctype     (lad_in),
        .ok        (dec_ok),
        .space     (dec_space),
        .host_data (dec_host)
    );

    lpc_win_check #(
        .WIN_BASE (WIN_BASE),
        .WIN_SIZE (WIN_SIZE)
    ) u_win (
        .addr (addr_shift),
        .hit  (win_hit)
    );

    lpc_lad_driver u_drv (
        .st      (q.st),
        .half    (q.cnt[0]),
        .ready   (sync_ready),
        .data    (q.data),
        .lad_out (lad_out),
        .lad_oe  (lad_oe)
    );

    always_comb begin
        d        = q;
        d.wr_stb = 1'b0;
        d.rd_stb = 1'b0;
        if (!lframe_n) begin
            // framing strobe wins over any phase: restart or drop
            d.st = (lad_in == NIB_START) ? ST_CTYPE : ST_IDLE;
        end else begin
            unique case (q.st)
                ST_IDLE: ;
                ST_CTYPE: begin
                    if (dec_ok) begin
                        d.space     = dec_space;
                        d.host_data = dec_host;
                        d.cnt       = '0;
                        d.addr      = '0;
                        d.st        = (dec_space == SP_DMA) ? ST_CHAN : ST_ADDR;
                    end else begin
                        d.st = ST_IDLE;
                    end
                end
                ST_ADDR: begin
                    d.addr = addr_shift;
                    d.cnt  = q.cnt + 3'd1;
                    if (q.cnt == last_nib) begin
                        d.cnt = '0;
                        if (q.space == SP_MEM && !win_hit)
                            d.st = ST_IDLE;
                        else
                            d.st = q.host_data ? ST_WDATA : ST_TAR_IN;
                    end
                end
                ST_CHAN: begin
                    d.addr = {{(ADDR_W-NIB_W){1'b0}}, lad_in};
                    d.st   = ST_SIZE;
                end
                ST_SIZE: begin
                    d.cnt = '0;
                    if (lad_in[1:0] == 2'b00)
                        d.st = q.host_data ? ST_WDATA : ST_TAR_IN;
                    else
                        d.st = ST_IDLE;
                end
                ST_WDATA: begin
                    if (!q.cnt[0]) begin
                        d.data[3:0] = lad_in;
                        d.cnt       = 3'd1;
                    end else begin
                        d.data[7:4] = lad_in;
                        d.cnt       = '0;
                        d.st        = ST_TAR_IN;
                    end
                end
                ST_TAR_IN: begin
                    if (!q.cnt[0]) begin
                        d.cnt = 3'd1;
                    end else begin
                        d.cnt    = '0;
                        d.wcnt   = '0;
                        d.st     = ST_SYNC;
                        d.wr_stb = q.host_data;
                        d.rd_stb = !q.host_data;
                    end
                end
                ST_SYNC: begin
                    if (q.rd_stb)
                        d.data = reg_rdata;
                    if (sync_ready) begin
                        d.cnt = '0;
                        d.st  = q.host_data ? ST_TAR_OUT : ST_RDATA;
                    end else begin
                        d.wcnt = q.wcnt + WCW'(1);
                    end
                end
                ST_RDATA: begin
                    if (!q.cnt[0]) begin
                        d.cnt = 3'd1;
                    end else begin
                        d.cnt = '0;
                        d.st  = ST_TAR_OUT;
                    end
                end
                ST_TAR_OUT: begin
                    if (!q.cnt[0]) begin
                        d.cnt = 3'd1;
                    end else begin
                        d.cnt = '0;
                        d.st  = ST_IDLE;
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st        <= ST_IDLE;
            q.space     <= SP_IO;
            q.host_data <= 1'b0;
            q.cnt       <= '0;
            q.wcnt      <= '0;
            q.addr      <= '0;
            q.data      <= '0;
            q.wr_stb    <= 1'b0;
            q.rd_stb    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign reg_addr  = q.addr;
    assign reg_space = q.space;
    assign reg_wdata = q.data;
    assign reg_wr    = q.wr_stb;
    assign reg_rd    = q.rd_stb;
endmodule

// File: rtl/lpc_target_engine_chk.sv
module lpc_target_engine_chk #(
    parameter logic [31:0] WIN_BASE = 32'hFFF0_0000,
    parameter logic [31:0] WIN_SIZE = 32'h0010_0000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        lframe_n,
    input logic [3:0]  lad_out,
    input logic        lad_oe,
    input logic [31:0] reg_addr,
    input logic [1:0]  reg_space,
    input logic        reg_wr,
    input logic        reg_rd
);
    localparam logic [31:0] WIN_LAST = WIN_BASE + WIN_SIZE - 32'd1;

    p_quiet_after_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lframe_n |=> !lad_oe);

    p_wr_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    p_rd_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);

    p_strobe_in_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr || reg_rd) |-> (lad_oe && (lad_out == 4'h5 || lad_out == 4'h0)));

    p_mem_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_wr || reg_rd) && reg_space == 2'b01) |->
            (WIN_SIZE != 32'd0 && reg_addr >= WIN_BASE && reg_addr <= WIN_LAST));

    p_dma_chan_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_wr || reg_rd) && reg_space == 2'b10) |-> (reg_addr[31:4] == 28'd0));

    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));
endmodule

bind lpc_target_engine lpc_target_engine_chk #(
    .WIN_BASE (WIN_BASE),
    .WIN_SIZE (WIN_SIZE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lframe_n  (lframe_n),
    .lad_out   (lad_out),
    .lad_oe    (lad_oe),
    .reg_addr  (reg_addr),
    .reg_space (reg_space),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd)
);

// File: tb/lpc_target_engine_tb.sv
module lpc_target_engine_tb;
    localparam int WAITS = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lframe_n = 1'b1;
    logic [3:0]  lad_in = 4'hF;
    logic [3:0]  lad_out;
    logic        lad_oe;
    logic [31:0] reg_addr;
    logic [1:0]  reg_space;
    logic [7:0]  reg_wdata;
    logic        reg_wr;
    logic        reg_rd;
    logic [7:0]  reg_rdata;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    typedef struct {
        bit          rd;
        logic [1:0]  sp;
        logic [31:0] addr;
        logic [7:0]  wd;
        string       req;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    // register-side model: read data is a fixed function of the access
    assign reg_rdata = reg_addr[7:0] ^ 8'hA5 ^ {6'b0, reg_space};

    lpc_target_engine #(.WAIT_CYC(WAITS)) u_dut (
        .clk(clk), .rst_n(rst_n), .lframe_n(lframe_n), .lad_in(lad_in),
        .lad_out(lad_out), .lad_oe(lad_oe), .reg_addr(reg_addr),
        .reg_space(reg_space), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] rd_model(input logic [31:0] a, input logic [1:0] sp);
        return a[7:0] ^ 8'hA5 ^ {6'b0, sp};
    endfunction

    // monitor: pops the scoreboard on every strobe
    always @(negedge clk) begin
        if (rst_n && (reg_wr || reg_rd)) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R8", "unexpected strobe addr", reg_addr, 32'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(reg_rd == e.rd && reg_wr == !e.rd, e.req, "strobe kind",
                    {30'b0, reg_wr, reg_rd}, {30'b0, !e.rd, e.rd});
                chk(reg_space == e.sp, e.req, "space", {30'b0, reg_space}, {30'b0, e.sp});
                chk(reg_addr == e.addr, e.req, "addr", reg_addr, e.addr);
                if (!e.rd)
                    chk(reg_wdata == e.wd, e.req, "wdata", {24'b0, reg_wdata}, {24'b0, e.wd});
            end
        end
    end

    task automatic send(input logic lf, input logic [3:0] nib);
        @(negedge clk);
        lframe_n = lf;
        lad_in   = nib;
    endtask

    // start nibble, then n nibbles of v, most significant first
    task automatic drive_host(input logic [63:0] v, input int n);
        send(1'b0, 4'h0);
        for (int i = n - 1; i >= 0; i--)
            send(1'b1, v[4*i +: 4]);
    endtask

    task automatic host_tar();
        send(1'b1, 4'hF);
        send(1'b1, 4'hF);
    endtask

    task automatic target_phase(input bit is_rd, input logic [7:0] exp, input string req);
        for (int i = 0; i < WAITS; i++) begin
            @(negedge clk);
            lframe_n = 1'b1; lad_in = 4'hF;
            chk(lad_oe && lad_out == 4'h5, "R5", "wait sync", {27'b0, lad_oe, lad_out}, 32'h15);
        end
        @(negedge clk);
        chk(lad_oe && lad_out == 4'h0, "R5", "ready sync", {27'b0, lad_oe, lad_out}, 32'h10);
        if (is_rd) begin
            @(negedge clk);
            chk(lad_oe && lad_out == exp[3:0], req, "read low nibble",
                {27'b0, lad_oe, lad_out}, {27'b1, 1'b1, exp[3:0]});
            @(negedge clk);
            chk(lad_oe && lad_out == exp[7:4], req, "read high nibble",
                {27'b0, lad_oe, lad_out}, {27'b1, 1'b1, exp[7:4]});
        end
        @(negedge clk);
        chk(lad_oe && lad_out == 4'hF, "R5", "closing turn-around", {27'b0, lad_oe, lad_out}, 32'h1F);
        @(negedge clk);
        chk(!lad_oe, "R5", "bus released", {31'b0, lad_oe}, 32'h0);
    endtask

    task automatic expect_silent(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            lframe_n = 1'b1; lad_in = 4'hF;
            chk(!lad_oe, req, "bus must stay released", {31'b0, lad_oe}, 32'h0);
        end
    endtask

    task automatic push(input bit rd, input logic [1:0] sp, input logic [31:0] a,
                        input logic [7:0] wd, input string req);
        exp_t e;
        e.rd = rd; e.sp = sp; e.addr = a; e.wd = wd; e.req = req;
        sb.push_back(e);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog expired");
                finish_run();
            end
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!lad_oe && !reg_wr && !reg_rd, "R1", "outputs in reset",
            {29'b0, lad_oe, reg_wr, reg_rd}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!lad_oe && !reg_wr && !reg_rd, "R1", "outputs after reset",
            {29'b0, lad_oe, reg_wr, reg_rd}, 32'h0);

        // R3: I/O write 0x12F4 <- 0x3C
        push(1'b0, 2'b00, 32'h0000_12F4, 8'h3C, "R3");
        drive_host(64'h2_12F4_C3, 7); host_tar();
        target_phase(1'b0, 8'h00, "R3");

        // R4: I/O read 0x0060 (type nibble with bit0 set)
        push(1'b1, 2'b00, 32'h0000_0060, 8'h00, "R4");
        drive_host(64'h1_0060, 5); host_tar();
        target_phase(1'b1, rd_model(32'h60, 2'b00), "R4");

        // R6: memory write inside window, base and last address
        push(1'b0, 2'b01, 32'hFFF8_1234, 8'h9E, "R6");
        drive_host(64'h6_FFF8_1234_E9, 11); host_tar();
        target_phase(1'b0, 8'h00, "R6");
        push(1'b0, 2'b01, 32'hFFF0_0000, 8'h01, "R6");
        drive_host(64'h6_FFF0_0000_10, 11); host_tar();
        target_phase(1'b0, 8'h00, "R6");
        push(1'b1, 2'b01, 32'hFFFF_FFFF, 8'h00, "R6");
        drive_host(64'h4_FFFF_FFFF, 9); host_tar();
        target_phase(1'b1, rd_model(32'hFFFF_FFFF, 2'b01), "R6");

        // R6: memory write just below the window is ignored
        drive_host(64'h6_FFEF_FFFF, 9);
        send(1'b1, 4'h5); send(1'b1, 4'hA);
        expect_silent(8, "R6");
        // R6: memory read far outside
        drive_host(64'h4_0000_1000, 9);
        expect_silent(8, "R6");

        // R7: DMA, host supplies byte, channel 3
        push(1'b0, 2'b10, 32'h0000_0003, 8'h71, "R7");
        drive_host(64'h8_3_0_17, 5); host_tar();
        target_phase(1'b0, 8'h00, "R7");
        // R7: DMA, target returns byte, channel 5 (size nibble upper bits set)
        push(1'b1, 2'b10, 32'h0000_0005, 8'h00, "R7");
        drive_host(64'hA_5_C, 3); host_tar();
        target_phase(1'b1, rd_model(32'h5, 2'b10), "R7");
        // R7: size 01 is ignored
        drive_host(64'h8_3_1, 3);
        send(1'b1, 4'h2); send(1'b1, 4'h4);
        expect_silent(8, "R7");

        // R8: unsupported types
        drive_host(64'hC_1234, 5);
        expect_silent(8, "R8");
        drive_host(64'hF, 1);
        expect_silent(8, "R8");

        // R2: abort an I/O write mid-address with a new start, then an I/O read
        send(1'b0, 4'h0); send(1'b1, 4'h2); send(1'b1, 4'h1); send(1'b1, 4'h2);
        push(1'b1, 2'b00, 32'h0000_ABCD, 8'h00, "R2");
        drive_host(64'h0_ABCD, 5); host_tar();
        target_phase(1'b1, rd_model(32'hABCD, 2'b00), "R2");

        // R2: abort with a non-start nibble, then silence
        send(1'b0, 4'h0); send(1'b1, 4'h0); send(1'b1, 4'h1);
        send(1'b0, 4'h3);
        expect_silent(10, "R2");

        // R2: start held for two clocks still yields one I/O write
        push(1'b0, 2'b00, 32'h0000_0080, 8'h5A, "R2");
        send(1'b0, 4'h0);
        drive_host(64'h2_0080_A5, 7); host_tar();
        target_phase(1'b0, 8'h00, "R2");

        expect_silent(4, "R9");
        chk(sb.size() == 0, "R9", "scoreboard drained", sb.size(), 32'h0);
        finish_run();
    end
endmodule